// File: doc/BRIEF.md
# DMA Channel Status and Byte-Count Register

This block holds the 32-bit combined status and byte-count word for one DMA channel. Software programs the byte count and reads the status through a simple register port. Writing a 1 to the done bit clears every status and error flag and aborts a transfer that is in flight. The transfer engine reports its events on dedicated inputs: start, channel selected, beat completed with its size, source and destination bus errors, and last transaction finished. The block tracks the remaining byte count and raises busy, request, done and the three error flags from those events.

The block checks the channel configuration each time a start arrives. The start is refused with a configuration error if the size encodings are unsupported, if the count is zero, or if the count or either address is not aligned to the transfer size. A count write above the legal range also raises the configuration error. The interrupt output follows the done flag.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset the byte count is 0 and the error, busy, request, done and interrupt outputs are all 0.
- R2: The read word carries 0 in bits 31 and 27, the configuration error in bit 30, the source bus error in bit 29, the destination bus error in bit 28, request in bit 26, busy in bit 25, done in bit 24, the constant 1110b in bits 23..20 and the byte count in bits 19..0.
- R3: A write with bit 24 = 0 while not busy loads bits 19..0 into the count when bits 23..20 are all zero. Otherwise it sets the configuration error and leaves the count unchanged.
- R4: A write with bit 24 = 0 while busy changes neither the count nor any flag.
- R5: A start while idle with done clear and the count at zero sets the configuration error and done, and busy stays 0.
- R6: Size encodings are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 = unsupported. A start with an unsupported size, a source address not a multiple of the source size, a destination address not a multiple of the destination size, or a count not a multiple of the larger size sets the configuration error and done.
- R7: A start while idle with done clear and a valid configuration sets busy. A start while busy or while done is set is ignored.
- R8: While busy, each completed beat lowers the count by its byte size (1, 2 or 4), saturating at 0.
- R9: Request reads 1 exactly when busy is set, the count is nonzero and the channel-selected input is 0.
- R10: While busy, a last-transaction event that leaves the count at zero clears busy and sets done.
- R11: While busy, a source bus error sets the source error flag, a destination bus error sets the destination error flag, and either one clears busy and sets done. No beat is counted in that cycle.
- R12: A write with bit 24 = 1 clears the configuration error, both bus error flags, busy and done, aborting the transfer, and does not load the count. A write with bit 24 = 0 never clears a flag.
- R13: The interrupt output equals the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read word |
| eng_start | input | 1 | Start request from the transfer engine |
| eng_sel | input | 1 | Channel currently selected by arbitration |
| beat_done | input | 1 | One beat completed |
| beat_bytes | input | 3 | Size of the completed beat in bytes |
| err_src | input | 1 | Bus error on the read phase |
| err_dst | input | 1 | Bus error on the write phase |
| last_done | input | 1 | Final transaction finished |
| src_size | input | 2 | Source size encoding |
| dst_size | input | 2 | Destination size encoding |
| src_addr_lsb | input | 2 | Two low bits of the source address |
| dst_addr_lsb | input | 2 | Two low bits of the destination address |
| byte_count | output | 20 | Remaining byte count |
| flag_cfg_err | output | 1 | Configuration error |
| flag_bus_err_src | output | 1 | Source bus error |
| flag_bus_err_dst | output | 1 | Destination bus error |
| flag_req | output | 1 | Request pending |
| flag_busy | output | 1 | Channel busy |
| flag_done | output | 1 | Transfer done |
| irq | output | 1 | Interrupt |

## Verification
Every flag and the count are registered one cycle after the event that moves them. A wrong internal state therefore shows on the read word and the flag outputs at the next clock edge. A missed decrement or a wrong saturation shows as a count mismatch in that cycle. It also shows later as a done that arrives too early or never. A clear-priority fault leaves a stale error or busy bit visible right after the abort write. A configuration-check fault turns a start into busy where done and the error were expected, or the reverse, one cycle after the start.

// File: rtl/dmas_pkg.sv
package dmas_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;

  function automatic logic size_legal(input logic [1:0] s);
    return s != SZ_BAD;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Low bits that must be zero for a given size
  function automatic logic lsb_misaligned(input logic [1:0] lsb, input logic [1:0] s);
    case (s)
      SZ_HALF: return lsb[0];
      SZ_WORD: return |lsb;
      default: return 1'b0;
    endcase
  endfunction

  // Larger of two legal size codes (codes grow with byte width)
  function automatic logic [1:0] size_max(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dmas_cfg_check.sv
module dmas_cfg_check #(
  parameter int CNT_W = 20
) (
  input  logic [1:0]       src_size,
  input  logic [1:0]       dst_size,
  input  logic [1:0]       src_lsb,
  input  logic [1:0]       dst_lsb,
  input  logic [CNT_W-1:0] count,
  output logic             cfg_bad
);
  import dmas_pkg::*;

  logic sizes_ok;
  logic cnt_zero;
  logic addr_bad;
  logic cnt_bad;

  always_comb begin
    sizes_ok = size_legal(src_size) && size_legal(dst_size);
    cnt_zero = (count == '0);
    addr_bad = lsb_misaligned(src_lsb, src_size) || lsb_misaligned(dst_lsb, dst_size);
    cnt_bad  = lsb_misaligned(count[1:0], size_max(src_size, dst_size));
    cfg_bad  = !sizes_ok || cnt_zero || addr_bad || cnt_bad;
  end

endmodule

// File: rtl/dmas_counter.sv
module dmas_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic [2:0]       dec_amt,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] a,
                                               input logic [2:0] b);
    logic [CNT_W-1:0] bw;
    bw = CNT_W'(b);
    return (a > bw) ? (a - bw) : '0;
  endfunction

  always_comb begin
    if (load)     count_nxt = load_val;
    else if (dec) count_nxt = sat_sub(count, dec_amt);
    else          count_nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

endmodule

// File: rtl/dmas_flags.sv
module dmas_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_ce,
  input  logic set_bes,
  input  logic set_bed,
  input  logic busy_set,
  input  logic busy_clr,
  input  logic done_set,
  output logic ce,
  output logic bes,
  output logic bed,
  output logic busy,
  output logic done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce   <= 1'b0;
      bes  <= 1'b0;
      bed  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (clr) begin
      ce   <= 1'b0;
      bes  <= 1'b0;
      bed  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      ce   <= ce  | set_ce;
      bes  <= bes | set_bes;
      bed  <= bed | set_bed;
      done <= done | done_set;
      if (busy_clr)      busy <= 1'b0;
      else if (busy_set) busy <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             eng_start,
  input  logic             eng_sel,
  input  logic             beat_done,
  input  logic [2:0]       beat_bytes,
  input  logic             err_src,
  input  logic             err_dst,
  input  logic             last_done,
  input  logic [1:0]       src_size,
  input  logic [1:0]       dst_size,
  input  logic [1:0]       src_addr_lsb,
  input  logic [1:0]       dst_addr_lsb,
  output logic [CNT_W-1:0] byte_count,
  output logic             flag_cfg_err,
  output logic             flag_bus_err_src,
  output logic             flag_bus_err_dst,
  output logic             flag_req,
  output logic             flag_busy,
  output logic             flag_done,
  output logic             irq
);

  localparam int FIELD_W = 24;
  localparam int FILL_W  = FIELD_W - CNT_W;
  localparam int DONE_B  = FIELD_W;
  localparam logic [FILL_W-1:0] FILL = {{(FILL_W-1){1'b1}}, 1'b0};

  // Named internal events
  logic clr_evt, wr_cnt, wr_big, load_ok, ovf_evt;
  logic cfg_bad, start_try, start_ok, start_bad;
  logic err_evt, beat_evt, fin_evt;
  logic [CNT_W-1:0] cnt_nxt;

  assign clr_evt   = reg_wr && reg_wdata[DONE_B];
  assign wr_cnt    = reg_wr && !reg_wdata[DONE_B];
  assign wr_big    = |reg_wdata[FIELD_W-1:CNT_W];
  assign load_ok   = wr_cnt && !flag_busy && !wr_big;
  assign ovf_evt   = wr_cnt && !flag_busy && wr_big;

  assign start_try = eng_start && !flag_busy && !flag_done && !clr_evt;
  assign start_ok  = start_try && !cfg_bad;
  assign start_bad = start_try && cfg_bad;

  assign err_evt   = flag_busy && !clr_evt && (err_src || err_dst);
  assign beat_evt  = flag_busy && !clr_evt && !err_evt && beat_done;
  assign fin_evt   = flag_busy && !clr_evt && !err_evt && last_done && (cnt_nxt == '0);

  dmas_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .src_size (src_size),
    .dst_size (dst_size),
    .src_lsb  (src_addr_lsb),
    .dst_lsb  (dst_addr_lsb),
    .count    (byte_count),
    .cfg_bad  (cfg_bad)
  );

  dmas_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ok),
    .load_val  (reg_wdata[CNT_W-1:0]),
    .dec       (beat_evt),
    .dec_amt   (beat_bytes),
    .count     (byte_count),
    .count_nxt (cnt_nxt)
  );

  dmas_flags u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_evt),
    .set_ce   (ovf_evt || start_bad),
    .set_bes  (err_evt && err_src),
    .set_bed  (err_evt && err_dst),
    .busy_set (start_ok),
    .busy_clr (err_evt || fin_evt),
    .done_set (start_bad || err_evt || fin_evt),
    .ce       (flag_cfg_err),
    .bes      (flag_bus_err_src),
    .bed      (flag_bus_err_dst),
    .busy     (flag_busy),
    .done     (flag_done)
  );

  assign flag_req  = flag_busy && !flag_done && (byte_count != '0) && !eng_sel;
  assign irq       = flag_done;
  assign reg_rdata = {1'b0, flag_cfg_err, flag_bus_err_src, flag_bus_err_dst,
                      1'b0, flag_req, flag_busy, flag_done, FILL, byte_count};

endmodule

// File: rtl/dmas_chk.sv
module dmas_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic             eng_sel,
  input logic             beat_done,
  input logic [2:0]       beat_bytes,
  input logic [CNT_W-1:0] byte_count,
  input logic             flag_cfg_err,
  input logic             flag_bus_err_src,
  input logic             flag_bus_err_dst,
  input logic             flag_req,
  input logic             flag_busy,
  input logic             flag_done,
  input logic             irq,
  input logic             clr_evt,
  input logic             start_ok,
  input logic             start_bad,
  input logic             err_evt,
  input logic             fin_evt
);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !flag_done && !flag_busy && !flag_cfg_err && !flag_bus_err_src && !flag_bus_err_dst);

  p_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq == flag_done);

  p_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_req |-> flag_busy && !eng_sel && (byte_count != '0));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_busy && reg_wr && !reg_wdata[24] && !beat_done |=> $stable(byte_count));

  p_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_busy && beat_done && !clr_evt && !err_evt && (beat_bytes != 3'd0)
    |=> (byte_count < $past(byte_count)) || (byte_count == '0));

  p_bad_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> flag_cfg_err && flag_done && !flag_busy);

  p_good_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> flag_busy && !flag_done);

  p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> flag_done && !flag_busy && (byte_count == '0));

  p_bus_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> flag_done && !flag_busy && (flag_bus_err_src || flag_bus_err_dst));

endmodule

bind dma_chan_stat dmas_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .reg_wr           (reg_wr),
  .reg_wdata        (reg_wdata),
  .eng_sel          (eng_sel),
  .beat_done        (beat_done),
  .beat_bytes       (beat_bytes),
  .byte_count       (byte_count),
  .flag_cfg_err     (flag_cfg_err),
  .flag_bus_err_src (flag_bus_err_src),
  .flag_bus_err_dst (flag_bus_err_dst),
  .flag_req         (flag_req),
  .flag_busy        (flag_busy),
  .flag_done        (flag_done),
  .irq              (irq),
  .clr_evt          (clr_evt),
  .start_ok         (start_ok),
  .start_bad        (start_bad),
  .err_evt          (err_evt),
  .fin_evt          (fin_evt)
);

// File: tb/dma_chan_stat_test.sv
`timescale 1ns/1ps
module dma_chan_stat_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start = 1'b0, eng_sel = 1'b0, beat_done = 1'b0;
  logic [2:0]  beat_bytes = 3'd0;
  logic        err_src = 1'b0, err_dst = 1'b0, last_done = 1'b0;
  logic [1:0]  src_size = 2'b00, dst_size = 2'b00;
  logic [1:0]  src_addr_lsb = 2'b00, dst_addr_lsb = 2'b00;
  logic [19:0] byte_count;
  logic        flag_cfg_err, flag_bus_err_src, flag_bus_err_dst;
  logic        flag_req, flag_busy, flag_done, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_chan_stat uut (.*);

  // Reference model state
  int m_cnt = 0;
  bit m_ce = 0, m_bes = 0, m_bed = 0, m_busy = 0, m_done = 0;

  function automatic int nbytes(input logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    if (s == 2'd2) return 4;
    return 0;
  endfunction

  function automatic bit start_refused();
    int sb, db, wide;
    sb = nbytes(src_size);
    db = nbytes(dst_size);
    if (sb == 0 || db == 0 || m_cnt == 0) return 1;
    wide = (sb > db) ? sb : db;
    if ((int'(src_addr_lsb) % sb) != 0) return 1;
    if ((int'(dst_addr_lsb) % db) != 0) return 1;
    if ((m_cnt % wide) != 0) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ce = 0; m_bes = 0; m_bed = 0; m_busy = 0; m_done = 0;
    end else if (reg_wr && reg_wdata[24]) begin
      m_ce = 0; m_bes = 0; m_bed = 0; m_busy = 0; m_done = 0;
    end else if (m_busy) begin
      if (err_src || err_dst) begin
        if (err_src) m_bes = 1;
        if (err_dst) m_bed = 1;
        m_busy = 0; m_done = 1;
      end else begin
        if (beat_done) m_cnt = (m_cnt > int'(beat_bytes)) ? m_cnt - int'(beat_bytes) : 0;
        if (last_done && m_cnt == 0) begin m_busy = 0; m_done = 1; end
      end
    end else begin
      if (eng_start && !m_done) begin
        if (start_refused()) begin m_ce = 1; m_done = 1; end
        else m_busy = 1;
      end
      if (reg_wr) begin
        if (reg_wdata[23:20] != 4'd0) m_ce = 1;
        else m_cnt = int'(reg_wdata[19:0]);
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare the whole output set to the model one step after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      bit e_req;
      logic [31:0] e_rd;
      e_req = m_busy && !m_done && m_cnt != 0 && !eng_sel;
      e_rd = {1'b0, m_ce, m_bes, m_bed, 1'b0, e_req, m_busy, m_done, 4'b1110, 20'(m_cnt)};
      chk("R8 count", byte_count, m_cnt);
      chk("R6 cfg_err", flag_cfg_err, m_ce);
      chk("R11 src_err", flag_bus_err_src, m_bes);
      chk("R11 dst_err", flag_bus_err_dst, m_bed);
      chk("R7 busy", flag_busy, m_busy);
      chk("R10 done", flag_done, m_done);
      chk("R9 req", flag_req, e_req);
      chk("R13 irq", irq, m_done);
      chk("R2 rdata", reg_rdata, e_rd);
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); eng_start = 1'b1;
    @(negedge clk); eng_start = 1'b0;
  endtask

  task automatic beat(input int b);
    @(negedge clk); beat_done = 1'b1; beat_bytes = 3'(b);
    @(negedge clk); beat_done = 1'b0; beat_bytes = 3'd0;
  endtask

  task automatic finish_last();
    @(negedge clk); last_done = 1'b1;
    @(negedge clk); last_done = 1'b0;
  endtask

  task automatic clear_all();
    wr(32'h0100_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", byte_count, 0);
    chk("R1 reset flags", {flag_cfg_err, flag_bus_err_src, flag_bus_err_dst, flag_req, flag_busy, flag_done, irq}, 0);
    chk("R2 reset word", reg_rdata, 32'h00E0_0000);

    // R3 legal and illegal count writes
    wr(32'h0000_0010);
    chk("R3 load", byte_count, 16);
    wr(32'h0010_0000);
    chk("R3 oversize sets cfg_err", flag_cfg_err, 1);
    chk("R3 oversize keeps count", byte_count, 16);
    clear_all();
    chk("R12 clear cfg_err", flag_cfg_err, 0);

    // R7 valid word transfer
    src_size = 2'b10; dst_size = 2'b10;
    pulse_start();
    chk("R7 busy after start", flag_busy, 1);
    chk("R9 req while unselected", flag_req, 1);
    eng_sel = 1'b1;
    @(negedge clk);
    chk("R9 req drops on select", flag_req, 0);
    wr(32'h0000_0055);
    chk("R4 write while busy ignored", byte_count, 16);
    pulse_start();
    chk("R7 start while busy ignored", flag_busy, 1);
    for (int i = 0; i < 4; i++) beat(4);
    chk("R8 count after beats", byte_count, 0);
    finish_last();
    eng_sel = 1'b0;
    chk("R10 done", flag_done, 1);
    chk("R10 busy clear", flag_busy, 0);
    chk("R13 irq", irq, 1);
    wr(32'h0000_0000);
    chk("R12 zero write keeps done", flag_done, 1);
    pulse_start();
    chk("R7 start while done ignored", flag_busy, 0);
    clear_all();
    chk("R13 irq cleared", irq, 0);

    // R5 zero count
    pulse_start();
    chk("R5 cfg_err", flag_cfg_err, 1);
    chk("R5 done", flag_done, 1);
    chk("R5 not busy", flag_busy, 0);
    clear_all();

    // R6 misaligned count
    wr(32'h0000_0006);
    pulse_start();
    chk("R6 count misaligned", flag_cfg_err, 1);
    clear_all();
    // R6 unsupported size
    wr(32'h0000_0008);
    src_size = 2'b11;
    pulse_start();
    chk("R6 bad size", flag_cfg_err, 1);
    clear_all();
    // R6 misaligned source
    src_size = 2'b01; dst_size = 2'b01; src_addr_lsb = 2'b01;
    pulse_start();
    chk("R6 src misaligned", flag_cfg_err, 1);
    clear_all();
    src_addr_lsb = 2'b00; dst_addr_lsb = 2'b10; dst_size = 2'b10;
    pulse_start();
    chk("R6 dst misaligned", flag_cfg_err, 1);
    clear_all();
    dst_addr_lsb = 2'b00;

    // R8 saturation
    src_size = 2'b00; dst_size = 2'b00;
    wr(32'h0000_0003);
    pulse_start();
    beat(2);
    chk("R8 partial", byte_count, 1);
    beat(2);
    chk("R8 saturate", byte_count, 0);
    finish_last();
    chk("R10 done after sat", flag_done, 1);
    clear_all();

    // R11 bus errors
    wr(32'h0000_0008);
    pulse_start();
    @(negedge clk); err_src = 1'b1; beat_done = 1'b1; beat_bytes = 3'd1;
    @(negedge clk); err_src = 1'b0; beat_done = 1'b0; beat_bytes = 3'd0;
    chk("R11 src flag", flag_bus_err_src, 1);
    chk("R11 no beat on error", byte_count, 8);
    chk("R11 done", flag_done, 1);
    clear_all();
    pulse_start();
    @(negedge clk); err_dst = 1'b1;
    @(negedge clk); err_dst = 1'b0;
    chk("R11 dst flag", flag_bus_err_dst, 1);
    chk("R11 busy cleared", flag_busy, 0);
    clear_all();

    // R12 abort
    pulse_start();
    beat(1);
    clear_all();
    chk("R12 abort busy", flag_busy, 0);
    chk("R12 abort keeps count", byte_count, 7);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule